// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller collects 32 peripheral interrupt request lines and turns them into one prioritised request for the processor. Each line is configured on its own to be level-sensitive or edge-triggered, and to be active-high or active-low. The controller keeps one pending flag per source and gates those flags with an enable mask. It picks the lowest-numbered enabled pending source and presents that source's number, its programmed handler address and its non-maskable attribute to the processor's dispatch logic.

Software reaches the controller through a flat word-addressed register port. The port covers:
- one handler-address register per source;
- one configuration register per source;
- the enable mask;
- the pending view, which also takes write-one-to-clear.

The dispatch logic reports a source it has taken through an acknowledge strobe that carries the source number. Requests are brought into the clock domain through a two-flop synchroniser before any mode logic sees them.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Each of the 32 request lines passes through a two-flop synchroniser. A level-mode source whose line becomes active shows as pending, and on `irq_req_o`, after exactly two rising clock edges. The pending view is read at address 65, with bit i for source i.
- R2: The handler-address registers sit at addresses 0 to 31, one per source. They read back what was written and have no reset value. While a request is presented, `irq_vec_o` equals the register of the source on `irq_id_o`.
- R3: After reset:
  - every configuration register (address 32+i) reads 0, which means level mode, active-high and maskable;
  - the mask (address 64) reads 0;
  - `irq_req_o` is low.
- R4: In level mode (configuration bit 0 = 0), the pending bit equals the polarity-corrected line and drops when the line goes inactive. Writing 1 to that bit at address 65 has no effect.
- R5: In edge mode (configuration bit 0 = 1), the pending bit is set by the leading edge, three rising clock edges after the line changes. Configuration bit 1 selects polarity:
  - bit 1 = 0 means active-high, so the rising edge is leading;
  - bit 1 = 1 means active-low, so the falling edge is leading.
  A trailing edge and a steady line set nothing.
- R6: An edge-latched pending bit stays set while the line is idle. It clears when 1 is written to its bit at address 65.
- R7: `ack_i` high for one cycle with `ack_id_i` = n clears the edge-latched pending bit of source n.
- R8: A source is eligible when it is pending and its mask bit (address 64, bit i) is 1. `irq_req_o` is high exactly when some source is eligible. `irq_id_o` is the lowest-numbered eligible source.
- R9: Configuration bit 2 marks a source as non-maskable. `irq_nmi_o` carries that bit for the source on `irq_id_o`.
- R10: A clear, by software write or by acknowledge, loses to a leading edge on the same source in the same cycle, so the pending bit stays set.
- R11: Writing a source's configuration to level mode discards any edge-latched pending state of that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 32 | Peripheral interrupt request lines, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| ack_i | input | 1 | Dispatcher has taken a source |
| ack_id_i | input | 5 | Number of the source taken |
| irq_req_o | output | 1 | An enabled pending source exists |
| irq_id_o | output | 5 | Number of the selected source |
| irq_vec_o | output | 32 | Handler address of the selected source |
| irq_nmi_o | output | 1 | Non-maskable attribute of the selected source |

## Verification
A leading edge that arrives at the pending logic can fall in the same cycle as a clear of that bit, either a write-one-to-clear or an acknowledge. The bench first latches a pending flag on an edge source and lets the line idle. It then raises the line again and times a write-one-to-clear so that the write is sampled on the very edge where the detected edge is registered. The bit must read as still pending afterwards. A behavioural model, compared on every clock, judges the request, number, vector and attribute outputs across that cycle and all others.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic nmi;      // bit 2
    logic act_low;  // bit 1
    logic edge_md;  // bit 0
  } src_cfg_t;

  localparam int CfgW = $bits(src_cfg_t);
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] raw_i,
  output logic [N_SRC-1:0] sync_o,
  output logic [N_SRC-1:0] prev_o
);
  logic [N_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] act_i,       // polarity-corrected current sample
  input  logic [N_SRC-1:0] prev_act_i,  // polarity-corrected previous sample
  input  logic [N_SRC-1:0] edge_mode_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q, lead_w;

  assign lead_w = act_i & ~prev_act_i & edge_mode_i;

  // a leading edge wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= ((pend_q & ~clr_i) | lead_w) & edge_mode_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_view
    assign pend_o[i] = edge_mode_i[i] ? pend_q[i] : act_i[i];
  end

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i & edge_mode_i)) == $past(pend_q & ~clr_i & edge_mode_i))); // R6
  AST_EDGE_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(lead_w)) == $past(lead_w))); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(clr_i & ~lead_w)) == '0)); // R7
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(edge_mode_i)) == '0)); // R11
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N_SRC = 32,
  localparam int IdxW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] elig_i,
  output logic             req_o,
  output logic [IdxW-1:0]  id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_i[i]) id_o = IdxW'(i);
    end
  end

  assign req_o = |elig_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC = 32,
  parameter int VEC_W = 32,
  localparam int IdxW  = $clog2(N_SRC),
  localparam int AddrW = $clog2(2 * N_SRC + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_lines_i,
  input  logic             reg_we_i,
  input  logic [AddrW-1:0] reg_addr_i,
  input  logic [VEC_W-1:0] reg_wdata_i,
  output logic [VEC_W-1:0] reg_rdata_o,
  input  logic             ack_i,
  input  logic [IdxW-1:0]  ack_id_i,
  output logic             irq_req_o,
  output logic [IdxW-1:0]  irq_id_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             irq_nmi_o
);
  import irqc_pkg::*;

  localparam logic [AddrW-1:0] CfgBase  = AddrW'(N_SRC);
  localparam logic [AddrW-1:0] MaskAddr = AddrW'(2 * N_SRC);
  localparam logic [AddrW-1:0] PendAddr = AddrW'(2 * N_SRC + 1);

  logic [VEC_W-1:0] vec_q [N_SRC];
  src_cfg_t         cfg_q [N_SRC];
  logic [N_SRC-1:0] mask_q;

  logic [N_SRC-1:0] mode_v, pol_v, nmi_v;
  logic [N_SRC-1:0] sync_v, prev_v, act_v, prev_act_v;
  logic [N_SRC-1:0] clr_v, ack_v, pend_v, elig_v;

  logic is_vec, is_cfg;
  logic [IdxW-1:0] cfg_idx;

  assign is_vec  = reg_addr_i < CfgBase;
  assign is_cfg  = (reg_addr_i >= CfgBase) && (reg_addr_i < MaskAddr);
  assign cfg_idx = IdxW'(reg_addr_i - CfgBase);

  // handler addresses carry no reset
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N_SRC; i++) begin
      if (reg_we_i && is_vec && reg_addr_i[IdxW-1:0] == IdxW'(i)) vec_q[i] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SRC; i++) cfg_q[i] <= '0;
      mask_q <= '0;
    end else if (reg_we_i) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (is_cfg && cfg_idx == IdxW'(i)) cfg_q[i] <= src_cfg_t'(reg_wdata_i[CfgW-1:0]);
      end
      if (reg_addr_i == MaskAddr) mask_q <= N_SRC'(reg_wdata_i);
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_cfg
    assign mode_v[i] = cfg_q[i].edge_md;
    assign pol_v[i]  = cfg_q[i].act_low;
    assign nmi_v[i]  = cfg_q[i].nmi;
    assign ack_v[i]  = ack_i && (ack_id_i == IdxW'(i));
  end

  irqc_sync #(.N_SRC(N_SRC)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (irq_lines_i),
    .sync_o (sync_v),
    .prev_o (prev_v)
  );

  assign act_v      = sync_v ^ pol_v;
  assign prev_act_v = prev_v ^ pol_v;
  assign clr_v      = ((reg_we_i && reg_addr_i == PendAddr) ? N_SRC'(reg_wdata_i) : '0) | ack_v;

  irqc_pending #(.N_SRC(N_SRC)) i_pending (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_v),
    .prev_act_i  (prev_act_v),
    .edge_mode_i (mode_v),
    .clr_i       (clr_v),
    .pend_o      (pend_v)
  );

  assign elig_v = pend_v & mask_q;

  irqc_prio #(.N_SRC(N_SRC)) i_prio (
    .elig_i (elig_v),
    .req_o  (irq_req_o),
    .id_o   (irq_id_o)
  );

  assign irq_vec_o = vec_q[irq_id_o];
  assign irq_nmi_o = nmi_v[irq_id_o];

  always_comb begin
    reg_rdata_o = '0;
    if (is_vec)                      reg_rdata_o = vec_q[reg_addr_i[IdxW-1:0]];
    else if (is_cfg)                 reg_rdata_o = VEC_W'(cfg_q[cfg_idx]);
    else if (reg_addr_i == MaskAddr) reg_rdata_o = VEC_W'(mask_q);
    else if (reg_addr_i == PendAddr) reg_rdata_o = VEC_W'(pend_v);
  end

  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (elig_v[irq_id_o] &&
                   ((elig_v & ((N_SRC'(1) << irq_id_o) - N_SRC'(1))) == '0))); // R8
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ack = 1'b0;
  logic [4:0]  ack_id = '0;
  logic        irq_req, irq_nmi;
  logic [4:0]  irq_id;
  logic [31:0] irq_vec;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .irq_lines_i(irq_lines),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .ack_i(ack), .ack_id_i(ack_id),
    .irq_req_o(irq_req), .irq_id_o(irq_id), .irq_vec_o(irq_vec), .irq_nmi_o(irq_nmi)
  );

  // behavioural reference
  logic [31:0] m_s1, m_s2, m_prev, m_pend, m_mask, m_mode, m_pol, m_nmi;
  logic [31:0] m_vec [32];
  logic [31:0] t_act, t_lead, t_clr;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
      m_mask <= '0; m_mode <= '0; m_pol <= '0; m_nmi <= '0;
    end else begin
      t_act  = m_s2 ^ m_pol;
      t_lead = t_act & ~(m_prev ^ m_pol) & m_mode;
      t_clr  = '0;
      if (reg_we && reg_addr == 7'd65) t_clr = reg_wdata;
      if (ack) t_clr[ack_id] = 1'b1;
      m_pend <= ((m_pend & ~t_clr) | t_lead) & m_mode;
      m_prev <= m_s2;
      m_s2   <= m_s1;
      m_s1   <= irq_lines;
      if (reg_we) begin
        if (reg_addr < 7'd32) m_vec[reg_addr[4:0]] <= reg_wdata;
        else if (reg_addr < 7'd64) begin
          m_mode[reg_addr - 7'd32] <= reg_wdata[0];
          m_pol[reg_addr - 7'd32]  <= reg_wdata[1];
          m_nmi[reg_addr - 7'd32]  <= reg_wdata[2];
        end else if (reg_addr == 7'd64) m_mask <= reg_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [31:0] elig;
      logic        e_req;
      int          e_id;
      elig  = ((m_mode & m_pend) | (~m_mode & (m_s2 ^ m_pol))) & m_mask;
      e_req = |elig;
      e_id  = 0;
      for (int i = 31; i >= 0; i--) if (elig[i]) e_id = i;
      chk("R8 model req", {31'b0, irq_req}, {31'b0, e_req});
      if (e_req) begin
        chk("R8 model id", {27'b0, irq_id}, e_id);
        chk("R2 model vec", irq_vec, m_vec[e_id]);
        chk("R9 model nmi", {31'b0, irq_nmi}, {31'b0, m_nmi[e_id]});
      end
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 7'(a);
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    rd(32, d); chk("R3 cfg0", d, 0);
    rd(50, d); chk("R3 cfg18", d, 0);
    rd(64, d); chk("R3 mask", d, 0);
    chk("R3 req", {31'b0, irq_req}, 0);

    for (int i = 0; i < 32; i++) wr(i, 32'h8000_0000 | (i << 4));
    rd(5, d); chk("R2 readback", d, 32'h8000_0050);
    wr(64, 32'hffff_ffff);

    irq_lines[7] = 1'b1;
    tick(); chk("R1 one edge", {31'b0, irq_req}, 0);
    tick(); chk("R1 two edges", {31'b0, irq_req}, 1);
    chk("R1 id", {27'b0, irq_id}, 7);
    chk("R2 vec", irq_vec, 32'h8000_0070);
    chk("R9 maskable", {31'b0, irq_nmi}, 0);
    rd(65, d); chk("R1 pend view", d, 32'h80);

    wr(65, 32'h80);
    rd(65, d); chk("R4 w1c ignored", d, 32'h80);
    irq_lines[7] = 1'b0;
    tick(); tick();
    chk("R4 level drop", {31'b0, irq_req}, 0);

    wr(35, 1);
    irq_lines[3] = 1'b1; tick();
    irq_lines[3] = 1'b0; tick();
    chk("R5 not yet", {31'b0, irq_req}, 0);
    tick();
    chk("R5 rise latched", {31'b0, irq_req}, 1);
    chk("R5 id", {27'b0, irq_id}, 3);
    repeat (4) tick();
    chk("R6 held", {31'b0, irq_req}, 1);
    wr(65, 32'h8);
    rd(65, d); chk("R6 w1c", d, 0);

    irq_lines[10] = 1'b1; repeat (4) tick();
    wr(42, 3);
    repeat (3) tick();
    chk("R5 steady low-active idle", {31'b0, irq_req}, 0);
    irq_lines[10] = 1'b0; repeat (4) tick();
    chk("R5 fall latched", {31'b0, irq_req}, 1);
    chk("R5 fall id", {27'b0, irq_id}, 10);
    irq_lines[10] = 1'b1; repeat (4) tick();
    rd(65, d); chk("R5 trailing no effect", d, 32'h400);

    irq_lines[3] = 1'b1; tick(); irq_lines[3] = 1'b0; repeat (5) tick();
    chk("R8 lowest", {27'b0, irq_id}, 3);
    wr(64, ~32'h8);
    chk("R8 masked skip", {27'b0, irq_id}, 10);
    wr(64, 0);
    chk("R8 none enabled", {31'b0, irq_req}, 0);
    wr(64, 32'hffff_ffff);

    ack = 1'b1; ack_id = 5'd3; tick(); ack = 1'b0;
    chk("R7 ack 3", {27'b0, irq_id}, 10);
    ack = 1'b1; ack_id = 5'd10; tick(); ack = 1'b0;
    chk("R7 ack 10", {31'b0, irq_req}, 0);

    wr(44, 4);
    irq_lines[12] = 1'b1; repeat (3) tick();
    chk("R9 nmi", {31'b0, irq_nmi}, 1);
    chk("R9 id", {27'b0, irq_id}, 12);
    irq_lines[12] = 1'b0; wr(44, 0); repeat (3) tick();

    irq_lines[3] = 1'b1; tick(); irq_lines[3] = 1'b0; repeat (5) tick();
    irq_lines[3] = 1'b1; tick(); tick();
    wr(65, 32'h8);
    rd(65, d); chk("R10 edge beats clear", d, 32'h8);

    irq_lines[3] = 1'b0; repeat (4) tick();
    rd(65, d); chk("R11 latched before", d, 32'h8);
    wr(35, 0);
    rd(65, d); chk("R11 discarded", d, 0);
    chk("R11 no request", {31'b0, irq_req}, 0);

    repeat (2) tick();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule